// File: doc/BRIEF.md
# Transmit Word Queue with Output Parity

This block sits between a host with a 16-bit data bus and a serializer that sends 32-bit words. The host builds each word with two strobes. The first strobe latches the low half. The second strobe supplies the high half and places the combined word in a 32-entry first-in first-out store. The serializer sees the oldest stored word on a parallel output and removes it with a pop pulse.

Three registered flags let the host pace its writes:
- an empty flag, which is also the "ready for a fresh block" indication;
- a below-half flag, which stays high while fewer than 16 words are held;
- a full flag.

Two configuration bits control bit 31 (the 32nd bit) of the presented word. With parity enabled, bit 31 is replaced by a parity bit computed over bits 30..0, and a second bit picks odd or even parity. With parity disabled, all 32 stored bits go out unchanged.

Top module: `tx_word_fifo`

## Requirements
- R1: A pulse on `wr_hi` stores the word {`wr_data`, latched low half}, with `wr_data` in bits 31..16. The low half is latched by a pulse on `wr_lo`. Words leave in the order they were stored.
- R2: The store holds up to 32 words. `tx_full` is high exactly when 32 words are held.
- R3: `tx_empty` is high exactly when no word is held. When `tx_empty` is low, `tx_word` presents the oldest word.
- R4: `tx_half_low` is high exactly when fewer than 16 words are held.
- R5: While `tx_full` is high, a `wr_hi` pulse is ignored. The count and the presented word do not change.
- R6: With `cfg_par_en`=1, bit 31 of `tx_word` is a parity bit. With `cfg_par_even`=0, the 32 output bits contain an odd number of ones. With `cfg_par_even`=1, they contain an even number.
- R7: With `cfg_par_en`=0, all 32 stored bits appear unchanged on `tx_word`.
- R8: Parity is formed from the configuration at the time the word is presented. A change of `cfg_par_en` or `cfg_par_even` alters the presented word within the same cycle, with no push or pop.
- R9: A `tx_pop` pulse while `tx_empty` is high is ignored. The store stays empty, and the next stored word is presented correctly.
- R10: A push and a pop in the same cycle (store neither full nor empty) leave the count unchanged. The popped word leaves and the new word joins at the tail.
- R11: A `wr_hi` pulse without a new `wr_lo` pulse reuses the last latched low half. After reset, that low half is zero.
- R12: After reset the store is empty: `tx_empty`=1, `tx_half_low`=1, `tx_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Strobe: latch `wr_data` as the low half |
| wr_hi | input | 1 | Strobe: `wr_data` is the high half; store the word |
| wr_data | input | 16 | Host data half |
| tx_pop | input | 1 | Serializer takes the presented word |
| cfg_par_en | input | 1 | 1: bit 31 replaced by parity |
| cfg_par_even | input | 1 | 0: odd parity, 1: even parity |
| tx_word | output | 32 | Oldest stored word, after parity insertion |
| tx_empty | output | 1 | No word held (ready) |
| tx_half_low | output | 1 | Fewer than 16 words held |
| tx_full | output | 1 | 32 words held |

## Verification
A wrong count shows up at the flags on the clock edge that follows the faulty push or pop. It appears as an early or late `tx_full`, `tx_half_low` or `tx_empty` transition. A wrong read or write pointer shows up at `tx_word` as soon as the affected slot reaches the head. The bench therefore drains the store fully several times, so every slot is compared in order. Parity faults are visible combinationally in the same cycle as a configuration change, without any traffic.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/txw_half_latch.sv
module txw_half_latch #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wr_data;
    end
  end
endmodule

// File: rtl/txw_store.sv
module txw_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 32,
  parameter int HALF   = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [WORD_W-1:0] push_word,
  output logic [WORD_W-1:0] head_word,
  output logic              empty_q,
  output logic              half_low_q,
  output logic              full_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt;
  logic push_ok, pop_ok;

  assign push_ok = push_req && !full_q;
  assign pop_ok  = pop_req && !empty_q;

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok) count_nxt = count + CW'(1);
    if (pop_ok && !push_ok) count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      empty_q    <= 1'b1;
      half_low_q <= 1'b1;
      full_q     <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      count      <= count_nxt;
      empty_q    <= (count_nxt == '0);
      half_low_q <= (count_nxt < CW'(HALF));
      full_q     <= (count_nxt == CW'(DEPTH));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R2
  AST_FULL_IGNORES_PUSH: assert property (@(posedge clk) disable iff (rst)
    full_q && push_req && !pop_req |=> full_q && count == $past(count)); // R5
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    empty_q && pop_req && !push_req |=> empty_q); // R9
  AST_PUSH_POP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok |=> count == $past(count)); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> !full_q && half_low_q); // R3
endmodule

// File: rtl/txw_parity_out.sv
module txw_parity_out #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] in_word,
  input  logic              par_en,
  input  logic              par_even,
  output logic [WORD_W-1:0] out_word
);
  logic body_xor;
  assign body_xor = ^in_word[WORD_W-2:0];

  always_comb begin
    out_word = in_word;
    if (par_en) out_word[WORD_W-1] = par_even ? body_xor : ~body_xor;
  end
endmodule

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
  import txw_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              tx_pop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_empty,
  output logic              tx_half_low,
  output logic              tx_full
);
  half_t lo_q;
  word_t head;

  txw_half_latch #(.HALF_W(HALF_W)) u_latch (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_data(wr_data), .lo_q(lo_q)
  );

  txw_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push_req(wr_hi), .pop_req(tx_pop),
    .push_word({wr_data, lo_q}),
    .head_word(head),
    .empty_q(tx_empty), .half_low_q(tx_half_low), .full_q(tx_full)
  );

  txw_parity_out #(.WORD_W(WORD_W)) u_par (
    .in_word(head), .par_en(cfg_par_en), .par_even(cfg_par_even), .out_word(tx_word)
  );

  AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (rst)
    cfg_par_en && !tx_empty |-> (^tx_word) == !cfg_par_even); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !cfg_par_en |-> tx_word == head); // R7
endmodule

// File: tb/tx_word_fifo_bench.sv
module tx_word_fifo_bench;
  logic clk = 1'b0;
  logic rst;
  logic wr_lo, wr_hi, tx_pop, cfg_par_en, cfg_par_even;
  logic [15:0] wr_data;
  logic [31:0] tx_word;
  logic tx_empty, tx_half_low, tx_full;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mq[$];
  logic [15:0] m_lo;

  always #5 clk = ~clk;

  tx_word_fifo u_tx_word_fifo (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .tx_pop(tx_pop), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .tx_word(tx_word), .tx_empty(tx_empty), .tx_half_low(tx_half_low), .tx_full(tx_full)
  );

  function automatic logic [31:0] exp_word(logic [31:0] w, logic en, logic even);
    logic [31:0] r = w;
    int ones = 0;
    if (en) begin
      for (int i = 0; i < 31; i++) ones += int'(w[i]);
      r[31] = even ? ((ones % 2) == 1) : ((ones % 2) == 0);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    int n = mq.size();
    chk(tx_empty == (n == 0), "R3 empty flag", 32'(tx_empty), 32'(n == 0));
    chk(tx_half_low == (n < 16), "R4 half flag", 32'(tx_half_low), 32'(n < 16));
    chk(tx_full == (n == 32), "R2 full flag", 32'(tx_full), 32'(n == 32));
    if (n > 0) begin
      logic [31:0] e = exp_word(mq[0], cfg_par_en, cfg_par_even);
      chk(tx_word == e, cfg_par_en ? "R1/R6 head word" : "R1/R7 head word", tx_word, e);
    end
  endtask

  task automatic step(input logic lo, input logic hi, input logic [15:0] d,
                      input logic pop, input logic en, input logic even);
    int n;
    wr_lo = lo; wr_hi = hi; wr_data = d; tx_pop = pop;
    cfg_par_en = en; cfg_par_even = even;
    n = mq.size();
    if (pop && n > 0) void'(mq.pop_front());
    if (hi && n < 32) mq.push_back({d, m_lo});
    if (lo) m_lo = d;
    @(posedge clk);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0; tx_pop = 0;
    check_outputs();
  endtask

  task automatic push_word(input logic [31:0] w, input logic en, input logic even);
    step(1, 0, w[15:0], 0, en, even);
    step(0, 1, w[31:16], 0, en, even);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    rst = 1; wr_lo = 0; wr_hi = 0; wr_data = '0; tx_pop = 0;
    cfg_par_en = 0; cfg_par_even = 0; m_lo = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    chk(tx_empty === 1'b1, "R12 empty after reset", 32'(tx_empty), 32'd1);
    chk(tx_half_low === 1'b1, "R12 half flag after reset", 32'(tx_half_low), 32'd1);
    chk(tx_full === 1'b0, "R12 full after reset", 32'(tx_full), 32'd0);

    // R11 second half with no first half: low half is zero after reset
    step(0, 1, 16'hBEEF, 0, 0, 0);
    chk(tx_word == 32'hBEEF_0000, "R11 reuse of reset low half", tx_word, 32'hBEEF_0000);
    step(0, 1, 16'h1234, 0, 0, 0);
    step(1, 0, 16'h5678, 0, 0, 0);
    step(0, 1, 16'h9ABC, 0, 0, 0);
    step(0, 1, 16'hDEF0, 0, 0, 0);
    chk(mq[3] == 32'hDEF0_5678, "R11 reused latched half in model", mq[3], 32'hDEF0_5678);

    // Fill to full (R2, R4 transitions)
    while (mq.size() < 32) push_word($urandom(), 0, 0);
    held = tx_word;
    // R5 push while full is ignored
    step(1, 0, 16'h1111, 0, 0, 0);
    step(0, 1, 16'h2222, 0, 0, 0);
    chk(tx_full == 1'b1 && tx_word == held, "R5 push while full", tx_word, held);
    // push and pop while full: pop only
    step(0, 1, 16'h3333, 1, 0, 0);
    chk(tx_full == 1'b0, "R5 push ignored with pop at full", 32'(tx_full), 32'd0);

    // R8 parity follows config without traffic
    held = mq[0];
    step(0, 0, 0, 0, 1, 0);
    chk(tx_word == exp_word(held, 1, 0), "R8 odd parity on config change", tx_word, exp_word(held, 1, 0));
    step(0, 0, 0, 0, 1, 1);
    chk(tx_word == exp_word(held, 1, 1), "R8 even parity on config change", tx_word, exp_word(held, 1, 1));
    step(0, 0, 0, 0, 0, 1);
    chk(tx_word == held, "R7 parity off passes bit 31", tx_word, held);

    // Drain in order (R1)
    while (mq.size() > 0) step(0, 0, 0, 1, 1, 0);
    // R9 pop on empty ignored
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(tx_empty == 1'b1, "R9 pop on empty", 32'(tx_empty), 32'd1);
    push_word(32'hCAFE_F00D, 0, 0);
    chk(tx_word == 32'hCAFE_F00D, "R9 word after empty pops", tx_word, 32'hCAFE_F00D);

    // R10 simultaneous push and pop at count 1
    step(1, 0, 16'hAAAA, 0, 0, 0);
    step(0, 1, 16'h5555, 1, 0, 0);
    chk(tx_empty == 1'b0 && tx_word == 32'h5555_AAAA, "R10 push with pop", tx_word, 32'h5555_AAAA);
    step(0, 0, 0, 1, 0, 0);
    chk(tx_empty == 1'b1, "R10 count kept at one", 32'(tx_empty), 32'd1);

    // Random traffic with bursts toward full and empty
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int bias = (i / 500) % 2;
      logic en = ($urandom_range(0, 3) != 0);
      logic ev = 1'($urandom_range(0, 1));
      logic pp = (bias == 1) ? ($urandom_range(0, 99) < 70) : ($urandom_range(0, 99) < 25);
      if (r < 40) step(1, 0, 16'($urandom()), pp, en, ev);
      else if (r < 85) step(0, 1, 16'($urandom()), pp, en, ev);
      else step(0, 0, 16'($urandom()), pp, en, ev);
    end
    while (mq.size() > 0) step(0, 0, 0, 1, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule